// File: doc/BRIEF.md
# Configuration Readback Command Sequencer

This block is a bus master for the parallel configuration port of a programmable target device. After a start pulse it writes a fixed script of 32-bit packet words that halts the target and asks for a block of frame data. It then turns the port around, collects the returned frame words and turns the port back. A second script restarts the target and closes the session. Finally the block waits for the target's done indication.

The port is 8, 16 or 32 bits wide, set by a parameter. On a narrow port every 32-bit word goes out as several beats, most significant part first, and returned beats are put back together in the same order. The target first returns a fixed run of filler words, which the block throws away. The block also honours the target's busy handshake. Captured words leave on a plain data/valid stream, and the number of words to read is a parameter.

Top module: `cfg_readback_seq`

## Requirements
- R1: After reset, and while idle, `csN` and `rdwrSel` are both high, and `wordValid` and `doneOut` are low. A one-cycle `start` begins the session.
- R2: The session begins with five words in this order: 0xFFFFFFFF, 0x000000BB, 0x11220044, 0xFFFFFFFF, 0xAA995566.
- R3: Next come the request words, in order: NOOP (0x20000000); command header 0x30008001 with code 0x0000000B; NOOP; header with code 0x00000007; six NOOPs; header with code 0x00000004; NOOP; address header 0x30002001 with address 0x00000000; read header 0x28006000; long read header 0x48000000 with the word count (filler words plus `READ_WORDS`) in bits 26:0; then 32 NOOPs.
- R4: A write beat is a cycle with `csN` low and `rdwrSel` high. Each word takes 32/`BUS_W` consecutive beats, most significant slice first.
- R5: A change of `rdwrSel` in either direction happens only while `csN` is high. `csN` stays high for exactly one cycle at each turnaround.
- R6: A read beat is taken only in a cycle where `csN` is low, `rdwrSel` is low and `busy` is low. Data present while `busy` is high is ignored.
- R7: The first `DUMMY_WORDS`*32/`BUS_W` read beats are dropped. Later beats are assembled most significant slice first. Each full word is shown on `wordOut` with `wordValid` high for one cycle.
- R8: Exactly `READ_WORDS` words are delivered, and the read ends right after the last beat.
- R9: After the read, the closing words follow in this order: 0x30008001, 0x00000005, NOOP, 0x30008001, 0x00000007, NOOP, 0x30008001, 0x0000000D, NOOP, NOOP.
- R10: After the closing words, `csN` stays high until `doneIn` is seen high. Then `doneOut` pulses for exactly one cycle and the block is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the port's bus clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a readback session when idle |
| doneIn | input | 1 | Done indication from the target |
| busy | input | 1 | Target busy; read data is invalid while high |
| cfgDataIn | input | BUS_W | Read data from the target |
| cfgDataOut | output | BUS_W | Write data to the target |
| csN | output | 1 | Active-low chip select |
| rdwrSel | output | 1 | Direction select: high = write, low = read |
| wordOut | output | 32 | Captured frame word |
| wordValid | output | 1 | One-cycle strobe for `wordOut` |
| doneOut | output | 1 | One-cycle pulse when the session is complete |

## Verification
The bench runs a full session on a byte-wide port twice. In the first run `busy` is held only for the read latency. In the second run `busy` also rises again in the middle of the read. Matching results in the two runs show that stalled beats are neither taken nor skipped. Every returned word carries a distinct value, and every filler beat is marked so it cannot be mistaken for frame data. This shows that the filler boundary is exact and that beats are ordered most significant first. The written words are rebuilt from the port beats and compared with the script, the count in the long read header included. The turnaround gaps and the done pulse are counted cycle by cycle.

// File: rtl/cfg_readback_pkg.sv
package cfg_readback_pkg;

  localparam logic [31:0] WORD_PAD    = 32'hFFFF_FFFF;
  localparam logic [31:0] WORD_WDET0  = 32'h0000_00BB;
  localparam logic [31:0] WORD_WDET1  = 32'h1122_0044;
  localparam logic [31:0] WORD_SYNC   = 32'hAA99_5566;
  localparam logic [31:0] WORD_NOOP   = 32'h2000_0000;
  localparam logic [31:0] HDR_CMD     = 32'h3000_8001;
  localparam logic [31:0] HDR_ADDR    = 32'h3000_2001;
  localparam logic [31:0] HDR_RD0     = 32'h2800_6000;
  localparam logic [31:0] HDR_LONGRD  = 32'h4800_0000;
  localparam logic [31:0] CODE_HALT   = 32'h0000_000B;
  localparam logic [31:0] CODE_CRCRST = 32'h0000_0007;
  localparam logic [31:0] CODE_RDFRM  = 32'h0000_0004;
  localparam logic [31:0] CODE_RESUME = 32'h0000_0005;
  localparam logic [31:0] CODE_UNSYNC = 32'h0000_000D;

  localparam int PRE_LEN  = 56;  // words before the read
  localparam int POST_LEN = 10;  // words after the read
  localparam int IDX_W    = 7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WR_PRE, ST_GAP_RD, ST_READ, ST_GAP_WR, ST_WR_POST, ST_WAIT
  } seqState_t;

  typedef struct packed {
    logic        drive;
    logic [31:0] word;
    logic [1:0]  beat;
    logic        capture;
    logic        drop;
    logic        clear;
  } seqStrobe_t;

  function automatic logic [31:0] scriptWord(input logic [IDX_W-1:0] idx,
                                             input logic [26:0] rdCount);
    logic [31:0] w;
    w = WORD_NOOP;
    case (idx)
      7'd0:  w = WORD_PAD;
      7'd1:  w = WORD_WDET0;
      7'd2:  w = WORD_WDET1;
      7'd3:  w = WORD_PAD;
      7'd4:  w = WORD_SYNC;
      7'd6:  w = HDR_CMD;
      7'd7:  w = CODE_HALT;
      7'd9:  w = HDR_CMD;
      7'd10: w = CODE_CRCRST;
      7'd17: w = HDR_CMD;
      7'd18: w = CODE_RDFRM;
      7'd20: w = HDR_ADDR;
      7'd21: w = 32'h0000_0000;
      7'd22: w = HDR_RD0;
      7'd23: w = HDR_LONGRD | {5'd0, rdCount};
      7'd56: w = HDR_CMD;
      7'd57: w = CODE_RESUME;
      7'd59: w = HDR_CMD;
      7'd60: w = CODE_CRCRST;
      7'd62: w = HDR_CMD;
      7'd63: w = CODE_UNSYNC;
      default: w = WORD_NOOP;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/cfg_readback_ctrl.sv
module cfg_readback_ctrl
  import cfg_readback_pkg::*;
#(
  parameter int BUS_W       = 32,
  parameter int READ_WORDS  = 147558,
  parameter int DUMMY_WORDS = 42
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       doneIn,
  input  logic       busy,
  output logic       csN,
  output logic       rdwrSel,
  output logic       doneOut,
  output seqStrobe_t stb
);
  localparam int BEATS       = 32 / BUS_W;
  localparam int DROP_BEATS  = DUMMY_WORDS * BEATS;
  localparam int TOTAL_BEATS = (DUMMY_WORDS + READ_WORDS) * BEATS;
  localparam int RD_W        = $clog2(TOTAL_BEATS + 1);
  localparam logic [26:0] RD_COUNT = 27'(DUMMY_WORDS + READ_WORDS);

  seqState_t        state, stateNext;
  logic [IDX_W-1:0] idx, idxNext;
  logic [1:0]       beat, beatNext;
  logic [RD_W-1:0]  rdCnt, rdCntNext;
  logic             lastBeat;

  assign lastBeat = (beat == 2'(BEATS - 1));

  always_comb begin
    stateNext = state;
    idxNext   = idx;
    beatNext  = beat;
    rdCntNext = rdCnt;
    stb       = '0;
    stb.word  = scriptWord(idx, RD_COUNT);
    stb.beat  = beat;
    case (state)
      ST_IDLE: if (start) begin
        stateNext = ST_WR_PRE;
        idxNext   = '0;
        beatNext  = '0;
        stb.clear = 1'b1;
      end
      ST_WR_PRE, ST_WR_POST: begin
        stb.drive = 1'b1;
        beatNext  = lastBeat ? 2'd0 : beat + 2'd1;
        if (lastBeat) begin
          idxNext = idx + 1'b1;
          if (state == ST_WR_PRE && idx == IDX_W'(PRE_LEN - 1))
            stateNext = ST_GAP_RD;
          if (state == ST_WR_POST && idx == IDX_W'(PRE_LEN + POST_LEN - 1))
            stateNext = ST_WAIT;
        end
      end
      ST_GAP_RD: begin
        stateNext = ST_READ;
        rdCntNext = '0;
      end
      ST_READ: if (!busy) begin
        stb.capture = 1'b1;
        stb.drop    = (rdCnt < RD_W'(DROP_BEATS));
        rdCntNext   = rdCnt + 1'b1;
        if (rdCnt == RD_W'(TOTAL_BEATS - 1)) stateNext = ST_GAP_WR;
      end
      ST_GAP_WR: stateNext = ST_WR_POST;
      ST_WAIT:   if (doneIn) stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      idx     <= '0;
      beat    <= '0;
      rdCnt   <= '0;
      csN     <= 1'b1;
      rdwrSel <= 1'b1;
      doneOut <= 1'b0;
    end else begin
      state   <= stateNext;
      idx     <= idxNext;
      beat    <= beatNext;
      rdCnt   <= rdCntNext;
      csN     <= !(stateNext == ST_WR_PRE || stateNext == ST_WR_POST ||
                   stateNext == ST_READ);
      rdwrSel <= !(stateNext == ST_GAP_RD || stateNext == ST_READ);
      doneOut <= (state == ST_WAIT) && doneIn;
    end
  end

  // R5: direction changes only under a deselected port
  a_r5_turn_to_read: assert property (@(posedge clk) disable iff (rst)
    $fell(rdwrSel) |-> csN);
  a_r5_turn_to_write: assert property (@(posedge clk) disable iff (rst)
    $rose(rdwrSel) |-> csN);
  // R5: the gap before reading lasts a single cycle
  a_r5_gap_single: assert property (@(posedge clk) disable iff (rst)
    (csN && !rdwrSel) |=> !csN);
  // R6: a beat is taken only on a selected, non-busy read cycle
  a_r6_capture_qualified: assert property (@(posedge clk) disable iff (rst)
    stb.capture |-> (!csN && !rdwrSel && !busy));
  // R10: done is a single-cycle pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    doneOut |=> !doneOut);
  // R1: idle port is deselected and in write direction
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> (csN && rdwrSel));

endmodule

// File: rtl/cfg_readback_dp.sv
module cfg_readback_dp
  import cfg_readback_pkg::*;
#(
  parameter int BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  seqStrobe_t       stb,
  input  logic [BUS_W-1:0] cfgDataIn,
  output logic [BUS_W-1:0] cfgDataOut,
  output logic [31:0]      wordOut,
  output logic             wordValid
);
  localparam int BEATS = 32 / BUS_W;

  logic [31:0] shiftedOut;
  logic [31:0] asmReg, asmNext;
  logic [1:0]  asmCnt;

  assign shiftedOut = stb.word >> ((BEATS - 1 - int'(stb.beat)) * BUS_W);
  assign cfgDataOut = stb.drive ? shiftedOut[BUS_W-1:0] : '0;

  generate
    if (BEATS == 1) begin : g_wide
      assign asmNext = cfgDataIn;
    end else begin : g_narrow
      assign asmNext = {asmReg[31-BUS_W:0], cfgDataIn};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || stb.clear) begin
      asmReg    <= '0;
      asmCnt    <= '0;
      wordOut   <= '0;
      wordValid <= 1'b0;
    end else begin
      wordValid <= 1'b0;
      if (stb.capture && !stb.drop) begin
        asmReg <= asmNext;
        if (asmCnt == 2'(BEATS - 1)) begin
          asmCnt    <= '0;
          wordOut   <= asmNext;
          wordValid <= 1'b1;
        end else begin
          asmCnt <= asmCnt + 2'd1;
        end
      end
    end
  end

  // R7: a word appears only right after a kept beat
  a_r7_valid_after_beat: assert property (@(posedge clk) disable iff (rst)
    wordValid |-> $past(stb.capture && !stb.drop));
  // R4: the bus is quiet whenever no write beat is driven
  a_r4_quiet_bus: assert property (@(posedge clk) disable iff (rst)
    stb.capture |-> (cfgDataOut == '0));

endmodule

// File: rtl/cfg_readback_seq.sv
module cfg_readback_seq
  import cfg_readback_pkg::*;
#(
  parameter int BUS_W       = 32,
  parameter int READ_WORDS  = 147558,
  parameter int DUMMY_WORDS = 42
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             doneIn,
  input  logic             busy,
  input  logic [BUS_W-1:0] cfgDataIn,
  output logic [BUS_W-1:0] cfgDataOut,
  output logic             csN,
  output logic             rdwrSel,
  output logic [31:0]      wordOut,
  output logic             wordValid,
  output logic             doneOut
);
  seqStrobe_t stb;

  cfg_readback_ctrl #(
    .BUS_W(BUS_W), .READ_WORDS(READ_WORDS), .DUMMY_WORDS(DUMMY_WORDS)
  ) ctrl_i (
    .clk(clk), .rst(rst), .start(start), .doneIn(doneIn), .busy(busy),
    .csN(csN), .rdwrSel(rdwrSel), .doneOut(doneOut), .stb(stb)
  );

  cfg_readback_dp #(.BUS_W(BUS_W)) dp_i (
    .clk(clk), .rst(rst), .stb(stb), .cfgDataIn(cfgDataIn),
    .cfgDataOut(cfgDataOut), .wordOut(wordOut), .wordValid(wordValid)
  );

endmodule

// File: tb/cfg_readback_seq_tb.sv
module cfg_readback_seq_tb_top;
  localparam int BUS_W  = 8;
  localparam int BEATS  = 4;
  localparam int NWORDS = 6;
  localparam int NDUMMY = 42;
  localparam int LAT    = 1;
  localparam int DBEATS = NDUMMY * BEATS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic doneIn = 1'b0;
  logic busy;
  logic [BUS_W-1:0] cfgDataIn, cfgDataOut;
  logic csN, rdwrSel, wordValid, doneOut;
  logic [31:0] wordOut;

  int checks = 0;
  int failures = 0;
  bit stallOn = 1'b0;

  always #5 clk = ~clk;

  cfg_readback_seq #(.BUS_W(BUS_W), .READ_WORDS(NWORDS), .DUMMY_WORDS(NDUMMY)) dut_i (
    .clk(clk), .rst(rst), .start(start), .doneIn(doneIn), .busy(busy),
    .cfgDataIn(cfgDataIn), .cfgDataOut(cfgDataOut), .csN(csN), .rdwrSel(rdwrSel),
    .wordOut(wordOut), .wordValid(wordValid), .doneOut(doneOut)
  );

  function automatic logic [31:0] frameWord(input int k);
    return 32'h1357_9BDF + k * 32'h0102_0304;
  endfunction

  function automatic logic [31:0] expScript(input int i);
    logic [31:0] w;
    w = 32'h2000_0000;
    if (i == 0 || i == 3) w = 32'hFFFF_FFFF;
    if (i == 1) w = 32'h0000_00BB;
    if (i == 2) w = 32'h1122_0044;
    if (i == 4) w = 32'hAA99_5566;
    if (i == 6 || i == 9 || i == 17 || i == 56 || i == 59 || i == 62) w = 32'h3000_8001;
    if (i == 7) w = 32'h0000_000B;
    if (i == 10 || i == 60) w = 32'h0000_0007;
    if (i == 18) w = 32'h0000_0004;
    if (i == 20) w = 32'h3000_2001;
    if (i == 21) w = 32'h0;
    if (i == 22) w = 32'h2800_6000;
    if (i == 23) w = 32'h4800_0000 | (NDUMMY + NWORDS);
    if (i == 57) w = 32'h0000_0005;
    if (i == 63) w = 32'h0000_000D;
    return w;
  endfunction

  // target model: busy latency, optional mid-read stalls, beat stream
  logic [15:0] readCyc, streamIdx;
  always_ff @(posedge clk) begin
    if (rst || rdwrSel) begin
      readCyc   <= '0;
      streamIdx <= '0;
    end else if (!csN) begin
      readCyc <= readCyc + 16'd1;
      if (!busy) streamIdx <= streamIdx + 16'd1;
    end
  end
  assign busy = (readCyc < LAT) || (stallOn && readCyc[2:0] == 3'd5);
  always_comb begin
    int rel;
    logic [31:0] w;
    rel = int'(streamIdx) - DBEATS;
    if (rel < 0) cfgDataIn = 8'hE0 | 8'(streamIdx[3:0]);
    else begin
      w = frameWord(rel / BEATS) >> (8 * (BEATS - 1 - rel % BEATS));
      cfgDataIn = w[7:0];
    end
  end

  // monitors, sampled mid-cycle
  logic [31:0] wrQ[$];
  logic [31:0] capQ[$];
  logic [31:0] wrAsm;
  int wrBeat = 0;
  int gapRd = 0, gapWr = 0;
  bit afterRead = 1'b0;
  always @(negedge clk) begin
    if (!csN && rdwrSel) begin
      wrAsm = {wrAsm[23:0], cfgDataOut};
      wrBeat++;
      if (wrBeat == BEATS) begin wrQ.push_back(wrAsm); wrBeat = 0; end
      afterRead = 1'b0;
    end
    if (!csN && !rdwrSel) afterRead = 1'b1;
    if (csN && !rdwrSel) gapRd++;
    if (csN && rdwrSel && afterRead) gapWr++;
    if (wordValid) capQ.push_back(wordOut);
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    check(csN == 1'b1, "R1", "csN after reset", 32'(csN), 32'd1);
    check(rdwrSel == 1'b1, "R1", "rdwrSel after reset", 32'(rdwrSel), 32'd1);
    check(wordValid == 1'b0, "R1", "wordValid after reset", 32'(wordValid), 32'd0);
    check(doneOut == 1'b0, "R1", "doneOut after reset", 32'(doneOut), 32'd0);
  endtask

  task automatic runSession(input bit stall);
    int bad, doneCnt, earlyDone, csLow;
    stallOn = stall;
    wrQ.delete(); capQ.delete();
    gapRd = 0; gapWr = 0; wrBeat = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (wrQ.size() < 66) @(negedge clk);
    earlyDone = 0; csLow = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (doneOut) earlyDone++;
      if (!csN) csLow++;
    end
    check(wrQ.size() == 66, "R4", "written word count", 32'(wrQ.size()), 32'd66);
    bad = 0;
    for (int i = 0; i < 5; i++) if (wrQ[i] != expScript(i)) bad++;
    check(bad == 0, "R2", "preamble mismatches", 32'(bad), 32'd0);
    check(wrQ[23] == expScript(23), "R3", "long read header", wrQ[23], expScript(23));
    bad = 0;
    for (int i = 5; i < 56; i++) if (wrQ[i] != expScript(i)) bad++;
    check(bad == 0, "R3", "request word mismatches", 32'(bad), 32'd0);
    bad = 0;
    for (int i = 56; i < 66; i++) if (wrQ[i] != expScript(i)) bad++;
    check(bad == 0, "R9", "closing word mismatches", 32'(bad), 32'd0);
    check(gapRd == 1, "R5", "gap cycles before read", 32'(gapRd), 32'd1);
    check(gapWr == 1, "R5", "gap cycles after read", 32'(gapWr), 32'd1);
    check(capQ.size() == NWORDS, "R8", "delivered word count", 32'(capQ.size()), 32'(NWORDS));
    if (capQ.size() > 0)
      check(capQ[0] == frameWord(0), "R7", "first word after filler", capQ[0], frameWord(0));
    bad = 0;
    for (int i = 0; i < capQ.size() && i < NWORDS; i++) if (capQ[i] != frameWord(i)) bad++;
    check(bad == 0, "R6", "word mismatches with busy pattern", 32'(bad), 32'd0);
    check(earlyDone == 0 && csLow == 0, "R10", "idle wait before doneIn",
          32'(earlyDone + csLow), 32'd0);
    doneIn = 1'b1;
    doneCnt = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (doneOut) doneCnt++;
    end
    doneIn = 1'b0;
    check(doneCnt == 1, "R10", "done pulse cycles", 32'(doneCnt), 32'd1);
    check(csN && rdwrSel, "R1", "port idle after session", {csN, rdwrSel}, 32'd3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    testReset();
    runSession(1'b0);
    runSession(1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule